// File: doc/BRIEF.md
# Dual-port indirect pointer reader

This block sits beside a 6502-style core. It returns a 16-bit little-endian pointer in a single memory cycle. The storage is a byte-wide memory with two ports. Port 0 reads the low pointer byte at address A. Port 1, which is read-only, reads the high byte at A+1 at the same time. The core does not need a second sequential read to collect the high byte.

The block forms the pointer address for five indirect addressing modes:

- zero-page indirect;
- zero-page pre-indexed by X;
- zero-page indirect post-indexed by Y;
- absolute indirect;
- absolute pre-indexed by X.

Zero-page pointer addresses wrap inside page zero. Absolute pointer addresses wrap across the whole 16-bit space. For the post-indexed mode, Y is added to the fetched pointer to give the effective address.

Port 0 also serves ordinary byte reads and writes from the core. This shared use needs no packing because the memory is organised in bytes. A pointer request owns port 0 in the cycle it is raised. Results come back one cycle after the request, each with a valid flag.

Top module: `ptr_fetch_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after a reset edge, `ptr_valid` and `dp_valid` are both low.
- R2: When `req` is high with `mode`=0 (zero-page indirect), the next cycle gives `ptr_valid`=1 and `ptr_out`={M[(Z+1) mod 256], M[Z]}, where Z=`oper[7:0]`. For example, Z=$FF takes its high byte from $00.
- R3: When `mode`=1 (zero-page pre-indexed by X), Z is replaced by (`oper[7:0]`+`x_idx`) mod 256. The high byte is read from (Z+1) mod 256.
- R4: When `mode`=2 (zero-page post-indexed by Y), the pointer P is fetched as in R2. Then `ptr_out`=(P+`y_idx`) mod 65536, using the `y_idx` value present with the request.
- R5: When `mode`=3 (absolute indirect), `ptr_out`={M[(A+1) mod 65536], M[A]}, where A=`oper`. There is no page wrap, so $12FF takes its high byte from $1300.
- R6: When `mode`=4 (absolute pre-indexed by X), A is replaced by (`oper`+`x_idx`) mod 65536 before the lookup.
- R7: `ptr_valid` is high exactly in the cycle after a cycle with `req` high.
- R8: A data read (`dp_en`=1, `dp_we`=0, `req`=0) returns M[`dp_addr`] on `dp_rdata` one cycle later, with `dp_valid`=1.
- R9: A data write (`dp_en`=1, `dp_we`=1, `req`=0) stores `dp_wdata` into the storage that both ports read. Later data reads and the high-byte port see the new value. `dp_valid` stays low after a write.
- R10: A data access in the same cycle as `req` is discarded. No write takes place, and `dp_valid` is low in the next cycle.
- R11: The storage has 2^`MEM_AW` bytes (1024 by default). Any address, pointer or data, selects byte (address mod 2^`MEM_AW`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Pointer fetch request |
| mode | input | 3 | Addressing mode: 0 (zp), 1 (zp,X), 2 (zp),Y, 3 (abs), 4 (abs,X) |
| oper | input | 16 | Pointer operand: zero-page offset in bits 7:0, or an absolute address |
| x_idx | input | 8 | X index |
| y_idx | input | 8 | Y index |
| ptr_valid | output | 1 | `ptr_out` holds a result |
| ptr_out | output | 16 | Fetched pointer, or the effective address in mode 2 |
| dp_en | input | 1 | Data access enable |
| dp_we | input | 1 | Data access is a write |
| dp_addr | input | 16 | Data byte address |
| dp_wdata | input | 8 | Write data |
| dp_rdata | output | 8 | Read data |
| dp_valid | output | 1 | `dp_rdata` holds a read result |

## Verification
A pointer result is due one cycle after the edge that samples `req`. A data read result is due one cycle after the edge that samples the read. A write has no output of its own; its effect is due at the next access to that byte through either port.

The bench changes inputs only on a falling edge. It checks each result at the following falling edge, half a period after the rising edge that registers it. The bench keeps its own byte model, updated on every write it issues, and uses that model to compute every expected pointer.

The sweeps cover:

- every zero-page offset in the three zero-page modes, under several X and Y values;
- many absolute addresses, including page ends and $FFFF;
- aliased addresses;
- a write that collides with a fetch request.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

  typedef enum logic [2:0] {
    AM_ZP_IND   = 3'd0,
    AM_ZPX_IND  = 3'd1,
    AM_ZP_IND_Y = 3'd2,
    AM_ABS_IND  = 3'd3,
    AM_ABSX_IND = 3'd4
  } amode_e;

  function automatic logic is_page0(input logic [2:0] m);
    return (m == AM_ZP_IND) || (m == AM_ZPX_IND) || (m == AM_ZP_IND_Y);
  endfunction

  function automatic logic uses_x(input logic [2:0] m);
    return (m == AM_ZPX_IND) || (m == AM_ABSX_IND);
  endfunction

endpackage

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] oper,
  input  logic [DATA_W-1:0] x_idx,
  output logic [ADDR_W-1:0] lo_addr,
  output logic [ADDR_W-1:0] hi_addr
);

  logic [DATA_W-1:0] xv;
  logic [DATA_W-1:0] pg_lo;
  logic [DATA_W-1:0] pg_hi;
  logic [ADDR_W-1:0] full_lo;

  always_comb begin
    xv      = uses_x(mode) ? x_idx : '0;
    pg_lo   = oper[DATA_W-1:0] + xv;
    pg_hi   = pg_lo + DATA_W'(1);
    full_lo = oper + {{(ADDR_W-DATA_W){1'b0}}, xv};
    if (is_page0(mode)) begin
      lo_addr = {{(ADDR_W-DATA_W){1'b0}}, pg_lo};
      hi_addr = {{(ADDR_W-DATA_W){1'b0}}, pg_hi};
    end else begin
      lo_addr = full_lo;
      hi_addr = full_lo + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/ptr_dpram.sv
module ptr_dpram #(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 10,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              p0_en,
  input  logic              p0_we,
  input  logic [MEM_AW-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_en,
  input  logic [MEM_AW-1:0] p1_addr,
  output logic [DATA_W-1:0] p1_rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Port 0: read-first read/write port
  always_ff @(posedge clk) begin
    if (p0_en) begin
      if (p0_we) mem[p0_addr] <= p0_wdata;
      p0_rdata <= mem[p0_addr];
    end
  end

  // Port 1: read-only port
  always_ff @(posedge clk) begin
    if (p1_en) p1_rdata <= mem[p1_addr];
  end

endmodule

// File: rtl/ptr_yadd.sv
module ptr_yadd #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] lo_byte,
  input  logic [DATA_W-1:0] hi_byte,
  input  logic [DATA_W-1:0] y_val,
  input  logic              add_y,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ofs;

  always_comb begin
    ofs = add_y ? {{(ADDR_W-DATA_W){1'b0}}, y_val} : '0;
    ptr = {hi_byte, lo_byte} + ofs;
  end

endmodule

// File: rtl/ptr_fetch_unit.sv
module ptr_fetch_unit
  import ptr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 10,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] oper,
  input  logic [DATA_W-1:0] x_idx,
  input  logic [DATA_W-1:0] y_idx,
  output logic              ptr_valid,
  output logic [ADDR_W-1:0] ptr_out,
  input  logic              dp_en,
  input  logic              dp_we,
  input  logic [ADDR_W-1:0] dp_addr,
  input  logic [DATA_W-1:0] dp_wdata,
  output logic [DATA_W-1:0] dp_rdata,
  output logic              dp_valid
);

  logic [ADDR_W-1:0] lo_addr, hi_addr;
  logic [MEM_AW-1:0] p0_addr;
  logic              p0_en, p0_we;
  logic [DATA_W-1:0] rd_lo, rd_hi;
  logic              ptr_valid_q, dp_valid_q, add_y_q;
  logic [DATA_W-1:0] y_q;
  logic              unused_hi_bits;

  ptr_addr_gen #(.DATA_W(DATA_W)) u_agen (
    .mode    (mode),
    .oper    (oper),
    .x_idx   (x_idx),
    .lo_addr (lo_addr),
    .hi_addr (hi_addr)
  );

  // A pointer request owns port 0; data accesses in that cycle are dropped
  always_comb begin
    p0_en   = req | dp_en;
    p0_we   = ~req & dp_en & dp_we;
    p0_addr = req ? lo_addr[MEM_AW-1:0] : dp_addr[MEM_AW-1:0];
  end

  assign unused_hi_bits = ^{dp_addr, lo_addr, hi_addr};

  ptr_dpram #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_mem (
    .clk      (clk),
    .p0_en    (p0_en),
    .p0_we    (p0_we),
    .p0_addr  (p0_addr),
    .p0_wdata (dp_wdata),
    .p0_rdata (rd_lo),
    .p1_en    (req),
    .p1_addr  (hi_addr[MEM_AW-1:0]),
    .p1_rdata (rd_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_valid_q <= 1'b0;
      dp_valid_q  <= 1'b0;
    end else begin
      ptr_valid_q <= req;
      dp_valid_q  <= ~req & dp_en & ~dp_we;
    end
  end

  always_ff @(posedge clk) begin
    if (req) begin
      y_q     <= y_idx;
      add_y_q <= (mode == AM_ZP_IND_Y);
    end
  end

  ptr_yadd #(.DATA_W(DATA_W)) u_yadd (
    .lo_byte (rd_lo),
    .hi_byte (rd_hi),
    .y_val   (y_q),
    .add_y   (add_y_q),
    .ptr     (ptr_out)
  );

  assign ptr_valid = ptr_valid_q;
  assign dp_valid  = dp_valid_q;
  assign dp_rdata  = rd_lo;

endmodule

// File: rtl/ptr_fetch_chk.sv
module ptr_fetch_chk
  import ptr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic [2:0]        mode,
  input logic              dp_en,
  input logic              dp_we,
  input logic              ptr_valid,
  input logic              dp_valid,
  input logic [ADDR_W-1:0] lo_addr,
  input logic [ADDR_W-1:0] hi_addr
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // Checked at the falling edge, after the registers have settled
  always @(negedge clk) begin
    if (rst_d === 1'b1)
      assert_idle_after_reset_R1: assert (!ptr_valid && !dp_valid);
  end

  assert_valid_after_req_R7: assert property (@(posedge clk) disable iff (rst)
    req |=> ptr_valid);

  assert_no_valid_without_req_R7: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ptr_valid);

  // Covers the zero-page modes of R2 and R3
  assert_zp_in_page_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (req && is_page0(mode)) |->
      (lo_addr[ADDR_W-1:DATA_W] == '0) && (hi_addr[ADDR_W-1:DATA_W] == '0));

  assert_abs_hi_follows_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (req && mode == AM_ABS_IND) |-> (hi_addr == lo_addr + ADDR_W'(1)));

  assert_read_gives_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (dp_en && !dp_we && !req) |=> dp_valid);

  assert_write_no_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (dp_en && dp_we) |=> !dp_valid);

  assert_fetch_beats_data_R10: assert property (@(posedge clk) disable iff (rst)
    req |=> !dp_valid);

endmodule

bind ptr_fetch_unit ptr_fetch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .mode      (mode),
  .dp_en     (dp_en),
  .dp_we     (dp_we),
  .ptr_valid (ptr_valid),
  .dp_valid  (dp_valid),
  .lo_addr   (lo_addr),
  .hi_addr   (hi_addr)
);

// File: tb/sim_ptr_fetch_unit.sv
module sim_ptr_fetch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int MSIZE = 1024;

  logic        clk = 1'b0;
  logic        rst;
  logic        req;
  logic [2:0]  mode;
  logic [15:0] oper;
  logic [7:0]  x_idx, y_idx;
  logic        ptr_valid;
  logic [15:0] ptr_out;
  logic        dp_en, dp_we;
  logic [15:0] dp_addr;
  logic [7:0]  dp_wdata;
  logic [7:0]  dp_rdata;
  logic        dp_valid;

  int nvec = 0;
  int nerr = 0;
  logic [7:0] model [MSIZE];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_fetch_unit u0 (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .oper(oper),
    .x_idx(x_idx), .y_idx(y_idx), .ptr_valid(ptr_valid), .ptr_out(ptr_out),
    .dp_en(dp_en), .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
    .dp_rdata(dp_rdata), .dp_valid(dp_valid)
  );

  function automatic logic [7:0] mval(input logic [15:0] a);
    return model[a[9:0]];
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) ^ (i >> 3) ^ 8'h5C);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    req = 1'b0; dp_en = 1'b1; dp_we = 1'b1; dp_addr = a; dp_wdata = d;
    @(negedge clk);
    model[a[9:0]] = d;
    dp_en = 1'b0;
  endtask

  task automatic wr_chk(input logic [15:0] a, input logic [7:0] d);
    wr(a, d);
    check(dp_valid == 1'b0, "R9 no valid after write", {31'd0, dp_valid}, 32'd0);
  endtask

  task automatic rd_chk(input logic [15:0] a, input string tag);
    logic [7:0] e;
    e = mval(a);
    req = 1'b0; dp_en = 1'b1; dp_we = 1'b0; dp_addr = a;
    @(negedge clk);
    check(dp_valid && dp_rdata == e, tag, {23'd0, dp_valid, dp_rdata}, {23'd0, 1'b1, e});
    dp_en = 1'b0;
  endtask

  task automatic ptr_chk(input logic [2:0] m, input logic [15:0] op,
                         input logic [7:0] x, input logic [7:0] y, input string tag);
    logic [7:0]  zb, zb1;
    logic [15:0] la, ha, e;
    la = '0; ha = '0;
    case (m)
      3'd0, 3'd2: begin zb = op[7:0]; zb1 = zb + 8'd1; la = {8'h00, zb}; ha = {8'h00, zb1}; end
      3'd1: begin zb = op[7:0] + x; zb1 = zb + 8'd1; la = {8'h00, zb}; ha = {8'h00, zb1}; end
      3'd3: begin la = op; ha = op + 16'd1; end
      default: begin la = op + {8'h00, x}; ha = la + 16'd1; end
    endcase
    e = {mval(ha), mval(la)};
    if (m == 3'd2) e = e + {8'h00, y};
    req = 1'b1; mode = m; oper = op; x_idx = x; y_idx = y; dp_en = 1'b0;
    @(negedge clk);
    check(ptr_valid && ptr_out == e, tag, {15'd0, ptr_valid, ptr_out}, {15'd0, 1'b1, e});
    req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete (all requirements) actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [7:0] xs [4];
    logic [7:0] old;
    xs[0] = 8'h00; xs[1] = 8'h01; xs[2] = 8'h80; xs[3] = 8'hFF;
    rst = 1'b1; req = 1'b0; mode = '0; oper = '0; x_idx = '0; y_idx = '0;
    dp_en = 1'b0; dp_we = 1'b0; dp_addr = '0; dp_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset even with requests pending
    req = 1'b1; dp_en = 1'b1;
    @(negedge clk);
    check(!ptr_valid && !dp_valid, "R1 idle in reset", {30'd0, ptr_valid, dp_valid}, 32'd0);
    req = 1'b0; dp_en = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(!ptr_valid && !dp_valid, "R1 idle after reset", {30'd0, ptr_valid, dp_valid}, 32'd0);

    for (int i = 0; i < MSIZE; i++) wr(16'(i), pat(i));
    wr_chk(16'h0200, 8'h3C);

    // R8: read back every byte through port 0
    for (int i = 0; i < MSIZE; i++) rd_chk(16'(i), "R8 data read");
    @(negedge clk);
    check(!dp_valid, "R8 no valid when idle", {31'd0, dp_valid}, 32'd0);

    // R2: every zero-page pointer, including the $FF wrap
    for (int z = 0; z < 256; z++) ptr_chk(3'd0, 16'(z) | 16'hAB00, 8'h00, 8'h00, "R2 zp indirect");
    // R3: pre-index by X, wrapping in page zero
    for (int k = 0; k < 4; k++)
      for (int z = 0; z < 256; z++) ptr_chk(3'd1, 16'(z), xs[k], 8'h00, "R3 zp,X indirect");
    // R4: post-index by Y with carry into the high byte
    for (int k = 0; k < 4; k++)
      for (int z = 0; z < 256; z++) ptr_chk(3'd2, 16'(z), 8'h00, xs[k], "R4 (zp),Y");
    // R5: absolute pointers, page ends and top of memory
    for (int i = 0; i < 512; i++) ptr_chk(3'd3, 16'(i * 257 + 127), 8'h00, 8'h00, "R5 abs indirect");
    ptr_chk(3'd3, 16'h12FF, 8'h00, 8'h00, "R5 no page wrap");
    ptr_chk(3'd3, 16'hFFFF, 8'h00, 8'h00, "R5 wrap at top");
    // R6: absolute pre-indexed by X
    for (int i = 0; i < 512; i++) ptr_chk(3'd4, 16'(i * 389), 8'(i), 8'h00, "R6 abs,X indirect");
    ptr_chk(3'd4, 16'hFFFE, 8'h01, 8'h00, "R6 carry to top");
    ptr_chk(3'd4, 16'h00FF, 8'hFF, 8'h00, "R6 carry across page");

    // R7: valid drops when requests stop
    @(negedge clk);
    check(!ptr_valid, "R7 valid follows req", {31'd0, ptr_valid}, 32'd0);

    // R9: new writes are seen by both ports
    wr_chk(16'h0041, 8'hA5);
    wr_chk(16'h0040, 8'h5A);
    ptr_chk(3'd0, 16'h0040, 8'h00, 8'h00, "R9 write seen by both ports");
    rd_chk(16'h0041, "R9 write seen by data read");

    // R10: write colliding with a fetch is dropped
    old = mval(16'h0300);
    req = 1'b1; mode = 3'd0; oper = 16'h0020; dp_en = 1'b1; dp_we = 1'b1;
    dp_addr = 16'h0300; dp_wdata = ~old;
    @(negedge clk);
    check(ptr_valid && ptr_out == {mval(16'h0021), mval(16'h0020)}, "R10 fetch wins",
          {16'd0, ptr_out}, {16'd0, mval(16'h0021), mval(16'h0020)});
    req = 1'b0; dp_en = 1'b0;
    rd_chk(16'h0300, "R10 colliding write dropped");
    req = 1'b1; dp_en = 1'b1; dp_we = 1'b0;
    @(negedge clk);
    check(!dp_valid, "R10 colliding read dropped", {31'd0, dp_valid}, 32'd0);
    req = 1'b0; dp_en = 1'b0;

    // R11: high addresses alias onto the 1024-byte store
    wr_chk(16'hFC10, 8'h77);
    rd_chk(16'h0010, "R11 alias data read");
    ptr_chk(3'd3, 16'h040F, 8'h00, 8'h00, "R11 alias pointer");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule